// File: doc/BRIEF.md
# Byte-to-Word Write Packer

This block turns a byte-granular write request into a sequence of aligned 32-bit word program requests for a downstream word programmer. A request carries a start byte address and a byte length. The payload bytes then arrive one at a time on a byte stream, and the block places each byte in its lane of the current word. It hands each finished word downstream together with that word's aligned address. When the start address is not a multiple of four, the first word goes to the aligned address below it. When the request ends inside a word, the last word is partial. Every lane of a partial word that carries no payload byte is set to 0xFF, because programming a cell can only clear bits, so those lanes leave the stored bytes unchanged.

The downstream programmer answers each word with a one-cycle result pulse that can carry an error flag. The block sends no new word until the result for the previous one has arrived. A failed word ends the request at once with an error. Completion is a one-cycle pulse with an error flag and the number of payload bytes committed. The count includes only bytes of words that were confirmed, never padding.

All three flows follow the same valid/ready rules. A transfer happens on a clock edge where both valid and ready are high, and either side may stall for any number of cycles. The request port is ready only while the block is idle. The byte port is ready only while a word is being filled. A presented word holds its address and data stable until it is accepted.

Top module: `wp_byte_packer`

## Requirements
- R1: The request port is ready only while idle: ready is high out of reset, and it stays low from request acceptance until the cycle after the completion pulse.
- R2: The first word of a request goes to the start address with its two low bits cleared. Lanes below the start offset carry 0xFF. Every presented word address is a multiple of four.
- R3: The first word takes as many payload bytes as fit between the start offset and lane 3. If the request ends inside that word, the remaining upper lanes carry 0xFF.
- R4: Middle words carry four payload bytes with no padding, at addresses rising by four per word.
- R5: If 1 to 3 bytes remain after the last full word, a final word carries them in lanes 0 upward, with 0xFF in the rest.
- R6: A zero-length request produces the completion pulse on the cycle after acceptance, with count 0 and no error, and presents no word.
- R7: A result pulse with the error flag set ends the request. The completion pulse follows with the error flag set, no further word is presented, and no further payload byte is accepted.
- R8: Byte lane k occupies data bits 8k+7 down to 8k: lane 0 is the least significant byte. Payload bytes fill the lanes in stream order.
- R9: The completion count is the number of payload bytes in words confirmed without error. It equals the request length on success and excludes the failed word on error.
- R10: While a word is presented and not accepted, its address and data stay unchanged. No payload byte is accepted while a word is presented or awaiting its result.
- R11: Gaps in the byte stream and stalls on word acceptance change only the timing, never the words produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes, zero allowed |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken on this edge if valid |
| in_data | input | 8 | Payload byte |
| wr_valid | output | 1 | Word program request presented |
| wr_ready | input | 1 | Downstream takes the word on this edge |
| wr_addr | output | ADDR_W | Aligned byte address of the word |
| wr_data | output | 32 | Word, lane 0 in bits 7:0 |
| res_valid | input | 1 | One-cycle result of the outstanding word |
| res_err | input | 1 | Result reports a failed program |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request ended on a program error (valid with done) |
| done_count | output | LEN_W | Payload bytes committed (valid with done) |

## Verification
The bench builds the block with a 12-bit address and a 7-bit length, so requests of up to 64 bytes at any of the four start offsets cover every combination of head, middle and tail words within a short run. A downstream model stalls word acceptance on a configurable pattern and injects a failure at a chosen word index. A feeder inserts idle cycles between payload bytes. Together they drive error stops at the first word and at middle words, zero-length and single-byte requests, and requests that both start and end inside one word. Each request's words and completion values are checked against a packing model computed in the bench.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_SEND,
    ST_WAIT,
    ST_DONE
  } wp_state_e;
endpackage

// File: rtl/wp_lane_buf.sv
module wp_lane_buf #(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES),
  localparam int WORD_W = LANES * wp_pkg::BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      load,
  input  logic [SEL_W-1:0]          sel,
  input  logic [wp_pkg::BYTE_W-1:0] din,
  output logic [WORD_W-1:0]         word
);
  // Each lane resets and clears to all-ones so unfilled lanes program nothing.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [wp_pkg::BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '1;
      end else if (clear) begin
        lane_q <= '1;
      end else if (load && (sel == SEL_W'(g))) begin
        lane_q <= din;
      end
    end
    assign word[g*wp_pkg::BYTE_W +: wp_pkg::BYTE_W] = lane_q;
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LANES  = 4,
  localparam int SEL_W = $clog2(LANES),
  localparam int CNT_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  input  logic              res_valid,
  input  logic              res_err,
  output logic              done,
  output logic              done_err,
  output logic [LEN_W-1:0]  done_count,
  output logic              buf_clear,
  output logic              buf_load,
  output logic [SEL_W-1:0]  buf_sel
);
  wp_state_e         state_q;
  logic [ADDR_W-1:0] base_q;
  logic [SEL_W-1:0]  lane_q;
  logic [LEN_W-1:0]  remain_q;
  logic [CNT_W-1:0]  wbytes_q;
  logic [LEN_W-1:0]  commit_q;
  logic              err_q;

  logic req_fire, in_fire, res_ok, res_bad, word_full, last_byte;

  assign req_ready = (state_q == ST_IDLE);
  assign in_ready  = (state_q == ST_FILL);
  assign wr_valid  = (state_q == ST_SEND);
  assign done      = (state_q == ST_DONE);

  assign req_fire  = req_valid && req_ready;
  assign in_fire   = in_valid && in_ready;
  assign res_ok    = (state_q == ST_WAIT) && res_valid && !res_err;
  assign res_bad   = (state_q == ST_WAIT) && res_valid && res_err;
  assign word_full = (lane_q == SEL_W'(LANES - 1));
  assign last_byte = (remain_q == LEN_W'(1));

  assign buf_clear = req_fire || res_ok;
  assign buf_load  = in_fire;
  assign buf_sel   = lane_q;

  assign wr_addr    = base_q;
  assign done_err   = err_q;
  assign done_count = commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      lane_q   <= '0;
      remain_q <= '0;
      wbytes_q <= '0;
      commit_q <= '0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            base_q   <= {req_addr[ADDR_W-1:SEL_W], SEL_W'(0)};
            lane_q   <= req_addr[SEL_W-1:0];
            remain_q <= req_len;
            wbytes_q <= '0;
            commit_q <= '0;
            err_q    <= 1'b0;
            state_q  <= (req_len == '0) ? ST_DONE : ST_FILL;
          end
        end
        ST_FILL: begin
          if (in_fire) begin
            lane_q   <= lane_q + SEL_W'(1);
            remain_q <= remain_q - LEN_W'(1);
            wbytes_q <= wbytes_q + CNT_W'(1);
            if (word_full || last_byte) state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (wr_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (res_bad) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (res_ok) begin
            commit_q <= commit_q + LEN_W'(wbytes_q);
            base_q   <= base_q + ADDR_W'(LANES);
            lane_q   <= '0;
            wbytes_q <= '0;
            state_q  <= (remain_q == '0) ? ST_DONE : ST_FILL;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wp_byte_packer.sv
module wp_byte_packer #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int LANES  = 4,
  localparam int SEL_W  = $clog2(LANES),
  localparam int WORD_W = LANES * wp_pkg::BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [LEN_W-1:0]          req_len,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [wp_pkg::BYTE_W-1:0] in_data,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [WORD_W-1:0]         wr_data,
  input  logic                      res_valid,
  input  logic                      res_err,
  output logic                      done,
  output logic                      done_err,
  output logic [LEN_W-1:0]          done_count
);
  logic             buf_clear;
  logic             buf_load;
  logic [SEL_W-1:0] buf_sel;

  wp_ctrl #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .LANES (LANES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .res_valid (res_valid),
    .res_err   (res_err),
    .done      (done),
    .done_err  (done_err),
    .done_count(done_count),
    .buf_clear (buf_clear),
    .buf_load  (buf_load),
    .buf_sel   (buf_sel)
  );

  wp_lane_buf #(
    .LANES(LANES)
  ) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(buf_clear),
    .load (buf_load),
    .sel  (buf_sel),
    .din  (in_data),
    .word (wr_data)
  );
endmodule

// File: rtl/wp_byte_packer_chk.sv
module wp_byte_packer_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              res_valid,
  input logic              res_err,
  input logic              done,
  input logic              done_err,
  input logic [LEN_W-1:0]  done_count
);
  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_no_intake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);

  assert_zero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0)) |=> (done && !done_err && (done_count == '0)));

  assert_err_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err && !wr_valid && !in_ready && !req_ready && !done)
      |=> (done && done_err && !wr_valid));

  assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req_ready && !wr_valid && !in_ready) ##1 req_ready);
endmodule

bind wp_byte_packer wp_byte_packer_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_len   (req_len),
  .in_ready  (in_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .res_valid (res_valid),
  .res_err   (res_err),
  .done      (done),
  .done_err  (done_err),
  .done_count(done_count)
);

// File: tb/wp_byte_packer_tb.sv
`timescale 1ns/1ps
module wp_byte_packer_tb;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_data = '0;
  logic              wr_valid;
  logic              wr_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic              res_valid = 1'b0;
  logic              res_err = 1'b0;
  logic              done;
  logic              done_err;
  logic [LEN_W-1:0]  done_count;

  always #4 clk = ~clk;

  wp_byte_packer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .res_valid(res_valid), .res_err(res_err),
    .done(done), .done_err(done_err), .done_count(done_count)
  );

  int checks = 0;
  int errors = 0;
  bit all_done = 0;

  logic [7:0]  src [0:63];
  int          src_len, err_at, stall, gap;
  logic [31:0] got_data [0:31];
  int          got_addr [0:31];
  int          nwords, got_count;
  bit          finished, got_err, busy_viol, intake_viol;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic feeder();
    int i = 0;
    while (!finished && i < src_len) begin
      if (gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = src[i];
      #1;
      if (in_ready) i++;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic sink();
    bit pending = 0;
    int cyc = 0;
    while (!finished) begin
      res_valid = pending;
      res_err   = pending && (nwords - 1 == err_at);
      pending   = 0;
      wr_ready  = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == stall);
      cyc++;
      #1;
      if (wr_valid && in_ready) intake_viol = 1;
      if (wr_valid && wr_ready) begin
        got_addr[nwords] = int'(wr_addr);
        got_data[nwords] = wr_data;
        nwords++;
        pending = 1;
      end
      @(negedge clk);
    end
    wr_ready = 1'b0; res_valid = 1'b0; res_err = 1'b0;
  endtask

  task automatic monitor();
    while (!finished) begin
      #1;
      if (done) begin
        finished  = 1;
        got_err   = done_err;
        got_count = int'(done_count);
      end else if (req_ready) begin
        busy_viol = 1;
      end
      if (!finished) @(negedge clk);
    end
  endtask

  // Issue one request, run it to completion, compare with the packing model.
  task automatic run(input int addr, input int len, input int seed, input int e_at,
                     input int stall_i, input int gap_i, input string tag);
    logic [31:0] exp_data [0:31];
    int          exp_addr [0:31];
    int          exp_nb   [0:31];
    int          nw = 0, i = 0, lane, exp_words, exp_count;
    bit          exp_err;
    for (int k = 0; k < len; k++) src[k] = 8'((k * 37 + seed * 11 + 5) & 8'hFF);
    src_len = len; err_at = e_at; stall = stall_i; gap = gap_i;
    // model
    lane = addr % 4;
    while (i < len) begin
      exp_data[nw] = '1;
      exp_nb[nw]   = 0;
      exp_addr[nw] = (addr - (addr % 4)) + 4 * nw;
      while (lane < 4 && i < len) begin
        exp_data[nw][lane*8 +: 8] = src[i];
        exp_nb[nw]++;
        i++; lane++;
      end
      lane = 0;
      nw++;
    end
    exp_err   = (e_at >= 0) && (e_at < nw);
    exp_words = exp_err ? e_at + 1 : nw;
    exp_count = 0;
    for (int w = 0; w < (exp_err ? e_at : nw); w++) exp_count += exp_nb[w];
    // drive
    nwords = 0; finished = 0; busy_viol = 0; intake_viol = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    #1;
    check(req_ready == 1'b1, "R1", {tag, " ready when idle"}, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    fork
      feeder();
      sink();
      monitor();
    join
    @(negedge clk);
    check(nwords == exp_words, "R7", {tag, " word count"}, nwords, exp_words);
    for (int w = 0; w < exp_words && w < nwords; w++) begin
      check(got_addr[w] == exp_addr[w], "R2", {tag, " word address"}, got_addr[w], exp_addr[w]);
      check(got_data[w] == exp_data[w], "R8", {tag, " word data"}, got_data[w], exp_data[w]);
    end
    check(got_err == exp_err, "R7", {tag, " error flag"}, got_err, exp_err);
    check(got_count == exp_count, "R9", {tag, " committed count"}, got_count, exp_count);
    check(!busy_viol, "R1", {tag, " request port low while busy"}, busy_viol, 0);
    check(!intake_viol, "R10", {tag, " no byte intake while word pending"}, intake_viol, 0);
    #1;
    check(req_ready == 1'b1, "R1", {tag, " idle after done"}, req_ready, 1);
  endtask

  task automatic t_reset();
    #1;
    check(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    check(wr_valid == 1'b0, "R1", "reset wr_valid", wr_valid, 0);
    check(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
    check(done == 1'b0, "R1", "reset done", done, 0);
  endtask

  task automatic t_zero_len();      run(12'h040, 0, 1, -1, 0, 0, "R6 zero length");        endtask
  task automatic t_aligned();       run(12'h100, 12, 2, -1, 0, 0, "R4 R8 aligned full");   endtask
  task automatic t_inside_first();  run(12'h101, 2, 3, -1, 0, 0, "R3 ends in first word"); endtask
  task automatic t_single_top();    run(12'h123, 1, 4, -1, 0, 0, "R2 single top lane");    endtask
  task automatic t_head_mid();      run(12'h203, 9, 5, -1, 0, 0, "R2 R4 head and middle"); endtask
  task automatic t_head_tail();     run(12'h302, 7, 6, -1, 0, 0, "R5 head middle tail");   endtask
  task automatic t_tail_only();     run(12'h010, 6, 7, -1, 0, 0, "R5 aligned tail");       endtask
  task automatic t_stalls();        run(12'h081, 13, 8, -1, 2, 1, "R10 R11 stalls");       endtask
  task automatic t_err_middle();    run(12'h0C1, 14, 9, 2, 1, 0, "R7 R9 error middle");    endtask
  task automatic t_err_first();     run(12'h0E2, 10, 10, 0, 0, 0, "R7 error first word");  endtask
  task automatic t_long();          run(12'h3C1, 64, 11, -1, 0, 0, "R4 long request");     endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_aligned();
    t_inside_first();
    t_single_top();
    t_head_mid();
    t_head_tail();
    t_tail_only();
    t_stalls();
    t_err_middle();
    t_err_first();
    t_aligned();
    t_long();
    all_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!all_done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule